// File: doc/BRIEF.md
# ChaCha Round Sequencer

This block runs the core permutation of the ChaCha family on a sixteen-word state of 32-bit words. It has one adder, one xor and one left rotator, and uses them in turn. It does not build four quarter-round datapaths. A five-bit step number selects the operand words, and the word numbers come from a computed schedule. One pass has 32 steps: the four column quarter-rounds, then the four diagonal quarter-rounds. The block repeats the pass for a configurable number of double rounds, ten by default.

To use it, write the state one word at a time through the load port while the block is idle, then pulse `start`. `busy` stays high for the whole run. `done` pulses for one cycle when the run ends, and the permuted words can then be read through the word-addressed read port. The block has no key or nonce setup, no final feed-forward addition and no keystream combining.

Each schedule step is one line of a quarter-round (an add, then an xor, then a rotate) and takes three clock cycles. The latency is therefore fixed at 3 × 32 × DOUBLE_ROUNDS cycles.

Top module: `chacha_round_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0, and every state word reads 0 on `rd_word`.
- R2: While idle, `load_en` writes `load_data` into word `load_idx` (0 to 15) on the clock edge, and that word reads back on `rd_word` when `rd_idx` selects it.
- R3: `start` sampled while idle raises `busy` on the next edge, and `busy` then stays high for exactly 3 × 32 × DOUBLE_ROUNDS cycles (960 by default).
- R4: `done` is high for exactly one cycle: the first cycle in which `busy` is low again after a run.
- R5: The result equals DOUBLE_ROUNDS repetitions of the following. First, quarter-rounds on the word tuples (a,b,c,d) = (0,4,8,12), (1,5,9,13), (2,6,10,14), (3,7,11,15). Then quarter-rounds on (0,5,10,15), (1,6,11,12), (2,7,8,13), (3,4,9,14). Each quarter-round runs a+=b; d^=a; d<<<=16; c+=d; b^=c; b<<<=12; a+=b; d^=a; d<<<=8; c+=d; b^=c; b<<<=7, in that order.
- R6: All additions wrap modulo 2^32.
- R7: `load_en` and `start` have no effect while `busy` is high. The run completes with the result of the state that was loaded before it started.
- R8: `rd_word` reads 0 while `busy` is high.
- R9: An all-zero state stays all-zero after a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Write one state word (idle only) |
| load_idx | input | 4 | Word number to write |
| load_data | input | 32 | Word value to write |
| start | input | 1 | Begin a run (idle only) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rd_idx | input | 4 | Word number to read |
| rd_word | output | 32 | Selected word, 0 while busy |

## Verification
The hardest case to reach from the ports is a write or a start that arrives in the middle of a run. It must leave the 960-cycle schedule and the final words untouched. The stimulus pulses `load_en` and `start` at a chosen cycle deep inside a run, probes `rd_word` in the same cycle, and then compares all sixteen words with a bench model of the state loaded before the run. Wrap-around is reached with all-ones states, and the zero fixed point with an all-zero state. A sweep of pseudo-random and single-bit states checks the operand ordering of every quarter-round.

// File: rtl/chacha_seq_pkg.sv
// Shared constants and types for the ChaCha round sequencer.
// Assumes 32-bit words and a sixteen-word state; the schedule has 32 steps.
package chacha_seq_pkg;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 16;
    localparam int IDX_W     = $clog2(NUM_WORDS);
    localparam int STEPS     = 32;
    localparam int STEP_W    = $clog2(STEPS);
    localparam int ROT_W     = $clog2(WORD_W);

    // Sub-cycle of one schedule step
    typedef enum logic [1:0] {
        PH_ADD = 2'd0,
        PH_XOR = 2'd1,
        PH_ROT = 2'd2
    } phase_e;

    // Operand selection for one step
    typedef struct packed {
        logic [IDX_W-1:0] add_dst;
        logic [IDX_W-1:0] add_src;
        logic [IDX_W-1:0] mix_dst;
        logic [ROT_W-1:0] rot_amt;
    } step_ops_t;
endpackage

// File: rtl/chacha_step_map.sv
// Step map: turns a schedule step number into operand word numbers.
// step[4] picks column (0) or diagonal (1), step[3:2] picks the quarter-round,
// step[1:0] picks the line of the quarter-round. Purely combinational.
module chacha_step_map
    import chacha_seq_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    output step_ops_t         ops
);
    logic       diag;
    logic [1:0] qsel;
    logic [1:0] line;
    logic [1:0] lane_b, lane_c, lane_d;
    logic [IDX_W-1:0] w_a, w_b, w_c, w_d;

    // Derive the four tuple words of the current quarter-round
    always_comb begin
        diag   = step[4];
        qsel   = step[3:2];
        line   = step[1:0];
        lane_b = qsel + (diag ? 2'd1 : 2'd0);
        lane_c = qsel + (diag ? 2'd2 : 2'd0);
        lane_d = qsel + (diag ? 2'd3 : 2'd0);
        w_a    = {2'b00, qsel};
        w_b    = {2'b01, lane_b};
        w_c    = {2'b10, lane_c};
        w_d    = {2'b11, lane_d};
    end

    // Pick operands and rotate amount for the line within the quarter-round
    always_comb begin
        if (line[0] == 1'b0) begin
            ops.add_dst = w_a;
            ops.add_src = w_b;
            ops.mix_dst = w_d;
        end else begin
            ops.add_dst = w_c;
            ops.add_src = w_d;
            ops.mix_dst = w_b;
        end
        case (line)
            2'd0:    ops.rot_amt = ROT_W'(16);
            2'd1:    ops.rot_amt = ROT_W'(12);
            2'd2:    ops.rot_amt = ROT_W'(8);
            default: ops.rot_amt = ROT_W'(7);
        endcase
    end
endmodule

// File: rtl/chacha_word_alu.sv
// Word ALU: one 32-bit add, xor or left-rotate chosen by the phase.
// Assumes the rotate amount is below the word width.
module chacha_word_alu
    import chacha_seq_pkg::*;
(
    input  phase_e            op,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic [ROT_W-1:0]  rot_amt,
    output logic [WORD_W-1:0] res
);
    logic [2*WORD_W-1:0] doubled;

    // Compute the result of the selected operation
    always_comb begin
        doubled = {opa, opa} << rot_amt;
        case (op)
            PH_ADD:  res = opa + opb;
            PH_XOR:  res = opa ^ opb;
            default: res = doubled[2*WORD_W-1:WORD_W];
        endcase
    end
endmodule

// File: rtl/chacha_seq_ctrl.sv
// Sequencer: walks phase, step and double-round counters for one run.
// Assumes start is ignored while busy; done pulses once when the run ends.
module chacha_seq_ctrl
    import chacha_seq_pkg::*;
#(
    parameter int DOUBLE_ROUNDS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output phase_e            phase,
    output logic [STEP_W-1:0] step
);
    localparam int ITER_W = (DOUBLE_ROUNDS > 1) ? $clog2(DOUBLE_ROUNDS) : 1;
    localparam int TOTAL  = 3 * STEPS * DOUBLE_ROUNDS;
    localparam int CNT_W  = $clog2(TOTAL + 1);

    logic [ITER_W-1:0] iter;
    logic              last_step;

    // Flag the final sub-cycle of a pass
    always_comb last_step = (phase == PH_ROT) && (step == STEP_W'(STEPS - 1));

    // Advance the counters and produce busy/done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            phase <= PH_ADD;
            step  <= '0;
            iter  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    phase <= PH_ADD;
                    step  <= '0;
                    iter  <= '0;
                end
            end else begin
                case (phase)
                    PH_ADD:  phase <= PH_XOR;
                    PH_XOR:  phase <= PH_ROT;
                    default: phase <= PH_ADD;
                endcase
                if (phase == PH_ROT) step <= step + 1'b1;
                if (last_step) begin
                    if (iter == ITER_W'(DOUBLE_ROUNDS - 1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                        iter <= '0;
                    end else begin
                        iter <= iter + 1'b1;
                    end
                end
            end
        end
    end

    // Independent count of busy cycles, used only by the latency check
    logic [CNT_W-1:0] run_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)              run_cnt <= '0;
        else if (start && !busy) run_cnt <= '0;
        else if (busy)           run_cnt <= run_cnt + 1'b1;
    end

    assert_busy_rises_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    assert_run_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt == CNT_W'(TOTAL)));
    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
endmodule

// File: rtl/chacha_round_seq.sv
// ChaCha round sequencer top: sixteen-word state register file, a shared
// add/xor/rotate ALU, the step map and the sequencer. Loads and starts are
// accepted only while idle; the read port returns 0 while a run is active.
module chacha_round_seq
    import chacha_seq_pkg::*;
#(
    parameter int DOUBLE_ROUNDS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic [WORD_W-1:0] load_data,
    input  logic              start,
    output logic              busy,
    output logic              done,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    phase_e            phase;
    logic [STEP_W-1:0] step;
    step_ops_t         ops;
    logic [WORD_W-1:0] st [NUM_WORDS];
    logic [WORD_W-1:0] opa, opb, alu_res;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [WORD_W-1:0] wr_val;

    chacha_seq_ctrl #(.DOUBLE_ROUNDS(DOUBLE_ROUNDS)) ctrl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done),
        .phase (phase),
        .step  (step)
    );

    chacha_step_map map_i (
        .step (step),
        .ops  (ops)
    );

    chacha_word_alu alu_i (
        .op      (phase),
        .opa     (opa),
        .opb     (opb),
        .rot_amt (ops.rot_amt),
        .res     (alu_res)
    );

    // Route operands from the state and choose the write port source
    always_comb begin
        opa = (phase == PH_ADD) ? st[ops.add_dst] : st[ops.mix_dst];
        opb = (phase == PH_ADD) ? st[ops.add_src] : st[ops.add_dst];
        if (busy) begin
            wr_en  = 1'b1;
            wr_idx = (phase == PH_ADD) ? ops.add_dst : ops.mix_dst;
            wr_val = alu_res;
        end else begin
            wr_en  = load_en;
            wr_idx = load_idx;
            wr_val = load_data;
        end
    end

    // One register per state word, written through the single write port
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)                                  st[w] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(w)))     st[w] <= wr_val;
        end
    end

    // Read port, blanked during a run
    always_comb rd_word = busy ? '0 : st[rd_idx];

    assert_add_operands_distinct_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ops.add_dst != ops.add_src) && (ops.mix_dst != ops.add_dst));
    assert_idle_state_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load_en && !$past(busy)) |=> $stable(st[rd_idx]) || busy || $past(rd_idx) != rd_idx);
endmodule

// File: tb/chacha_round_seq_tb.sv
// Bench for the ChaCha round sequencer: sweeps many states through full runs
// and compares against a quarter-round model written from the requirements.
module chacha_round_seq_tb_top;
    localparam int DR    = 10;
    localparam int TOTAL = 3 * 32 * DR;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [3:0]  load_idx = '0;
    logic [31:0] load_data = '0;
    logic        start = 1'b0;
    logic        busy, done;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_word;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    logic [31:0] ref_st [16];
    logic [31:0] seed = 32'h2545f491;

    always #2.5 clk = ~clk;

    chacha_round_seq #(.DOUBLE_ROUNDS(DR)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
        .load_data(load_data), .start(start), .busy(busy), .done(done),
        .rd_idx(rd_idx), .rd_word(rd_word)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] rotl(input logic [31:0] v, input int n);
        return (v << n) | (v >> (32 - n));
    endfunction

    task automatic qr(input int a, input int b, input int c, input int d);
        ref_st[a] = ref_st[a] + ref_st[b]; ref_st[d] = rotl(ref_st[d] ^ ref_st[a], 16);
        ref_st[c] = ref_st[c] + ref_st[d]; ref_st[b] = rotl(ref_st[b] ^ ref_st[c], 12);
        ref_st[a] = ref_st[a] + ref_st[b]; ref_st[d] = rotl(ref_st[d] ^ ref_st[a], 8);
        ref_st[c] = ref_st[c] + ref_st[d]; ref_st[b] = rotl(ref_st[b] ^ ref_st[c], 7);
    endtask

    task automatic model_run();
        for (int i = 0; i < DR; i++) begin
            qr(0, 4, 8, 12); qr(1, 5, 9, 13); qr(2, 6, 10, 14); qr(3, 7, 11, 15);
            qr(0, 5, 10, 15); qr(1, 6, 11, 12); qr(2, 7, 8, 13); qr(3, 4, 9, 14);
        end
    endtask

    function automatic logic [31:0] next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic load_ref();
        for (int w = 0; w < 16; w++) begin
            @(negedge clk);
            load_en = 1'b1; load_idx = 4'(w); load_data = ref_st[w];
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic read_check(input string req);
        for (int w = 0; w < 16; w++) begin
            rd_idx = 4'(w);
            #0.5;
            check(req, rd_word, ref_st[w]);
        end
    endtask

    // Run one block; optionally poke load/start at busy cycle poke_at (R7, R8)
    task automatic run_block(input int poke_at);
        int cnt;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R3 busy after start", {31'd0, busy}, 32'd1);
        cnt = 0;
        while (busy && cnt < TOTAL + 50) begin
            cnt++;
            if (cnt == poke_at) begin
                load_en = 1'b1; load_idx = 4'd5; load_data = 32'hdeadbeef; start = 1'b1;
                rd_idx = 4'd0;
                #0.5;
                check("R8 read zero while busy", rd_word, 32'd0);
            end
            @(negedge clk);
            load_en = 1'b0; start = 1'b0;
        end
        check("R3 busy length", cnt, TOTAL);
        check("R4 done at end", {31'd0, done}, 32'd1);
        read_check("R5 result word");
        @(negedge clk);
        check("R4 done one cycle", {31'd0, done}, 32'd0);
        check("R7 no restart", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        // Model self-check against a published quarter-round vector (R5)
        ref_st[0] = 32'h11111111; ref_st[4] = 32'h01020304;
        ref_st[8] = 32'h9b8d6f43; ref_st[12] = 32'h01234567;
        qr(0, 4, 8, 12);
        check("R5 model qr a", ref_st[0], 32'hea2a92f4);
        check("R5 model qr b", ref_st[4], 32'hcb1cf8ce);
        check("R5 model qr c", ref_st[8], 32'h4581472e);
        check("R5 model qr d", ref_st[12], 32'h5881c4bb);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        for (int w = 0; w < 16; w++) ref_st[w] = '0;
        read_check("R1 word");

        // R9 zero fixed point
        run_block(0);
        check("R9 zero stays zero", rd_word, 32'd0);

        // R2 load and readback
        for (int w = 0; w < 16; w++) ref_st[w] = 32'h01010101 * w + 32'h00a0b0c0;
        load_ref();
        read_check("R2 loaded word");
        model_run();
        run_block(0);

        // R6 wrap with all ones
        for (int w = 0; w < 16; w++) ref_st[w] = 32'hffffffff;
        load_ref();
        model_run();
        run_block(0);

        // R7/R8 mid-run load and start ignored
        for (int w = 0; w < 16; w++) ref_st[w] = next_rand();
        load_ref();
        model_run();
        run_block(417);

        // R5 single-bit states
        for (int b = 0; b < 4; b++) begin
            for (int w = 0; w < 16; w++) ref_st[w] = '0;
            ref_st[b * 5] = 32'h1 << (b * 7);
            load_ref();
            model_run();
            run_block(0);
        end

        // R5 pseudo-random sweep
        for (int r = 0; r < 10; r++) begin
            for (int w = 0; w < 16; w++) ref_st[w] = next_rand();
            load_ref();
            model_run();
            run_block((r % 2 == 1) ? 10 + r * 90 : 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule